// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked list of 16-byte transfer descriptors kept in a local descriptor memory. For each descriptor it emits one transfer request to a downstream data mover. A request carries a buffer address, a byte length, a direction bit, an ordering bit and a DMA mode, and it is sent over a valid/ready handshake. A walk starts when a start strobe is presented together with the byte pointer of the first descriptor. It ends with a one-cycle completion pulse after the last descriptor is accepted, or with a one-cycle error pulse when the chain is malformed.

Descriptor memory is read through a simple port that is 32 bits wide and has one cycle of read latency. A descriptor is read as four consecutive little-endian words:
- word 0 is the buffer address;
- word 1 is the length in 8-byte units;
- word 2 holds the flag byte in bits 7:0 and the mode in bits 11:8;
- word 3 is the byte pointer to the next descriptor.

Every descriptor pointer must be a multiple of 8. The walker fetches one descriptor, offers it downstream, and fetches the next one only after the handshake has completed.

Top module: `sg_chain_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `reqValid`, `memRdEn`, `chainDone` and `chainErr` are all low.
- R2: After an accepted start strobe, the four words of the descriptor are read at byte addresses ptr, ptr+4, ptr+8 and ptr+12, in the four cycles that follow the strobe edge. `reqValid` rises five clock edges after the strobe edge.
- R3: `reqAddr` equals word 0. `reqLen` equals word 1 shifted left by 3, which gives the length in bytes.
- R4: Word 2 is decoded as follows: bit 4 drives `reqOrdered`, bit 5 drives `reqOut` (1 means toward the device), and bits 11:8 drive `reqMode`. Bits 0–3, bit 6 and bits 31:12 have no effect on the outputs.
- R5: While `reqValid` is high and `reqReady` is low, the request stays asserted and every request field stays unchanged. No descriptor memory read is issued while a request is pending.
- R6: When a descriptor whose bit 7 of word 2 is clear is accepted, and its word 3 is nonzero with bits 2:0 equal to zero, the fetch of the descriptor at word 3 starts on the next edge. The next request rises five edges after the handshake edge.
- R7: When a descriptor with bit 7 of word 2 set is accepted, `chainDone` pulses for exactly one cycle after the handshake edge. No further read is issued, even if its word 3 is nonzero.
- R8: When a descriptor without the end bit is accepted and its word 3 is zero or not a multiple of 8, `chainErr` pulses for exactly one cycle after the handshake edge and the walk stops.
- R9: A start strobe whose pointer is zero or not a multiple of 8 produces a one-cycle `chainErr` pulse after the strobe edge, with no memory read and no request.
- R10: A start strobe that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStrobe | input | 1 | Starts a walk; sampled when the walker is idle |
| startPtr | input | PTR_W | Byte pointer to the first descriptor |
| memRdEn | output | 1 | Descriptor memory read enable |
| memRdAddr | output | PTR_W | Byte address of the descriptor word being read |
| memRdData | input | 32 | Read data, valid one cycle after `memRdEn` |
| reqValid | output | 1 | Transfer request valid |
| reqReady | input | 1 | Downstream accepts the request |
| reqAddr | output | PTR_W | Buffer address |
| reqLen | output | PTR_W+3 | Transfer length in bytes |
| reqOut | output | 1 | Direction, 1 = toward the device |
| reqOrdered | output | 1 | Ordered-transfer flag |
| reqMode | output | MODE_W | DMA transfer mode |
| chainDone | output | 1 | One-cycle pulse when the chain ends normally |
| chainErr | output | 1 | One-cycle pulse when the chain or the start pointer is malformed |

## Verification
The hardest case to reach from the ports is a start strobe that lands in the middle of a walk. It must be ignored, both during the fetch cycles and while a request is held waiting for `reqReady`. The bench reaches this case by stalling the handshake with a pseudo-random ready pattern, so the walk stays busy. It then pulses a second start, once with a misaligned pointer and once with a valid one. The reference model's exact read schedule and pulse timing would expose a walk that was wrongly accepted. Chains whose end descriptor carries a nonzero next pointer, and whose flag words are filled with junk in the undecoded bits, check the stop rule and the field decoding together.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  // Descriptor layout: four 32-bit little-endian words.
  localparam int DESC_WORDS = 4;
  localparam int WIDX_W = $clog2(DESC_WORDS);
  localparam int W_ADDR = 0;
  localparam int W_UNITS = 1;
  localparam int W_FLAGS = 2;
  localparam int W_NEXT = 3;

  // Bit positions inside the flag word.
  localparam int FLAG_ORDERED = 4;
  localparam int FLAG_OUTBOUND = 5;
  localparam int FLAG_LAST = 7;
  localparam int MODE_LSB = 8;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_FETCH,
    WALK_TAIL,
    WALK_EMIT
  } walkState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              loadStart;
    logic              loadNext;
    logic              rdEn;
    logic [WIDX_W-1:0] rdIdx;
    logic              capEn;
    logic [WIDX_W-1:0] capIdx;
  } walkCtl_t;

endpackage

// File: rtl/sg_walk_dp.sv
module sg_walk_dp
  import sg_walk_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int MODE_W = 4,
  parameter int LEN_SHIFT = 3,
  parameter int ALIGN_LOG2 = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkCtl_t                ctl,
  input  logic [PTR_W-1:0]        startPtr,
  input  logic [31:0]             memRdData,
  output logic [PTR_W-1:0]        memRdAddr,
  output logic [PTR_W-1:0]        reqAddr,
  output logic [PTR_W+LEN_SHIFT-1:0] reqLen,
  output logic                    reqOut,
  output logic                    reqOrdered,
  output logic [MODE_W-1:0]       reqMode,
  output logic                    descLast,
  output logic                    startBad,
  output logic                    nextBad
);

  localparam int LEN_W = PTR_W + LEN_SHIFT;

  logic [PTR_W-1:0]  curPtr;
  logic [PTR_W-1:0]  addrReg;
  logic [PTR_W-1:0]  unitsReg;
  logic [PTR_W-1:0]  nextReg;
  logic              ordReg;
  logic              outReg;
  logic              lastReg;
  logic [MODE_W-1:0] modeReg;

  // Current descriptor base pointer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr <= '0;
    end else if (ctl.loadStart) begin
      curPtr <= startPtr;
    end else if (ctl.loadNext) begin
      curPtr <= nextReg;
    end
  end

  assign memRdAddr = curPtr + (PTR_W'(ctl.rdIdx) << 2);

  // Capture the returning descriptor words, one field group per word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      unitsReg <= '0;
      nextReg  <= '0;
      ordReg   <= 1'b0;
      outReg   <= 1'b0;
      lastReg  <= 1'b0;
      modeReg  <= '0;
    end else if (ctl.capEn) begin
      if (ctl.capIdx == WIDX_W'(W_ADDR)) begin
        addrReg <= PTR_W'(memRdData);
      end
      if (ctl.capIdx == WIDX_W'(W_UNITS)) begin
        unitsReg <= PTR_W'(memRdData);
      end
      if (ctl.capIdx == WIDX_W'(W_FLAGS)) begin
        ordReg  <= memRdData[FLAG_ORDERED];
        outReg  <= memRdData[FLAG_OUTBOUND];
        lastReg <= memRdData[FLAG_LAST];
        modeReg <= memRdData[MODE_LSB +: MODE_W];
      end
      if (ctl.capIdx == WIDX_W'(W_NEXT)) begin
        nextReg <= PTR_W'(memRdData);
      end
    end
  end

  assign reqAddr    = addrReg;
  assign reqLen     = {unitsReg, {LEN_SHIFT{1'b0}}};
  assign reqOut     = outReg;
  assign reqOrdered = ordReg;
  assign reqMode    = modeReg;
  assign descLast   = lastReg;

  assign startBad = (startPtr == '0) || (|startPtr[ALIGN_LOG2-1:0]);
  assign nextBad  = (nextReg == '0) || (|nextReg[ALIGN_LOG2-1:0]);

  // R2: every read lands on a word inside an aligned descriptor.
  a_r2_word_aligned_read: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdEn |-> (memRdAddr[ALIGN_LOG2-1:0] == {ctl.rdIdx[0], 2'b00}));

  // R6: a next pointer is taken only when it is aligned and nonzero.
  a_r6_next_load_legal: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadNext |=> (curPtr != '0) && (curPtr[ALIGN_LOG2-1:0] == '0));

  // R9: a walk never begins from a bad pointer.
  a_r9_start_load_legal: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadStart |-> !startBad);

  logic unusedLen;
  assign unusedLen = ^reqLen[LEN_W-1:LEN_W-1];

endmodule

// File: rtl/sg_walk_ctl.sv
module sg_walk_ctl
  import sg_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startStrobe,
  input  logic     startBad,
  input  logic     reqReady,
  input  logic     descLast,
  input  logic     nextBad,
  output walkCtl_t ctl,
  output logic     reqValid,
  output logic     chainDone,
  output logic     chainErr
);

  walkState_t        state, stateNext;
  logic [WIDX_W-1:0] fetchIdx;
  logic              rdPendR;
  logic [WIDX_W-1:0] rdIdxR;
  logic              handshake;
  logic              startOk;
  logic              startRej;

  assign handshake = (state == WALK_EMIT) && reqReady;
  assign startOk   = (state == WALK_IDLE) && startStrobe && !startBad;
  assign startRej  = (state == WALK_IDLE) && startStrobe && startBad;

  always_comb begin
    stateNext = state;
    unique case (state)
      WALK_IDLE:  if (startOk) stateNext = WALK_FETCH;
      WALK_FETCH: if (fetchIdx == WIDX_W'(DESC_WORDS-1)) stateNext = WALK_TAIL;
      WALK_TAIL:  stateNext = WALK_EMIT;
      WALK_EMIT: begin
        if (handshake) begin
          stateNext = (descLast || nextBad) ? WALK_IDLE : WALK_FETCH;
        end
      end
      default:    stateNext = WALK_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadStart = startOk;
    ctl.loadNext  = handshake && !descLast && !nextBad;
    ctl.rdEn      = (state == WALK_FETCH);
    ctl.rdIdx     = fetchIdx;
    ctl.capEn     = rdPendR;
    ctl.capIdx    = rdIdxR;
  end

  assign reqValid = (state == WALK_EMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= WALK_IDLE;
      fetchIdx  <= '0;
      rdPendR   <= 1'b0;
      rdIdxR    <= '0;
      chainDone <= 1'b0;
      chainErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      fetchIdx  <= (state == WALK_FETCH) ? fetchIdx + WIDX_W'(1) : '0;
      rdPendR   <= ctl.rdEn;
      rdIdxR    <= ctl.rdIdx;
      chainDone <= handshake && descLast;
      chainErr  <= startRej || (handshake && !descLast && nextBad);
    end
  end

  // R5: a pending request is not withdrawn before it is accepted.
  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);

  // R5: no descriptor read while a request waits downstream.
  a_r5_no_read_pending: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !ctl.rdEn);

  // R2: the four word reads follow each other without gaps.
  a_r2_burst_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && (ctl.rdIdx != WIDX_W'(DESC_WORDS-1)))
      |=> (ctl.rdEn && (ctl.rdIdx == $past(ctl.rdIdx) + WIDX_W'(1))));

  // R7: the completion pulse follows an accepted request.
  a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |-> $past(reqValid && reqReady));

  // R7, R8: completion and error never coincide and last one cycle.
  a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chainDone, chainErr}));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |=> !chainDone);

  // R10: a walk in progress is not restarted by a new strobe.
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && (ctl.rdIdx != '0)) |=> !ctl.loadStart);

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sg_walk_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int MODE_W = 4,
  parameter int LEN_SHIFT = 3,
  parameter int ALIGN_LOG2 = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startStrobe,
  input  logic [PTR_W-1:0]           startPtr,
  output logic                       memRdEn,
  output logic [PTR_W-1:0]           memRdAddr,
  input  logic [31:0]                memRdData,
  output logic                       reqValid,
  input  logic                       reqReady,
  output logic [PTR_W-1:0]           reqAddr,
  output logic [PTR_W+LEN_SHIFT-1:0] reqLen,
  output logic                       reqOut,
  output logic                       reqOrdered,
  output logic [MODE_W-1:0]          reqMode,
  output logic                       chainDone,
  output logic                       chainErr
);

  walkCtl_t ctl;
  logic     descLast;
  logic     startBad;
  logic     nextBad;

  sg_walk_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .startBad    (startBad),
    .reqReady    (reqReady),
    .descLast    (descLast),
    .nextBad     (nextBad),
    .ctl         (ctl),
    .reqValid    (reqValid),
    .chainDone   (chainDone),
    .chainErr    (chainErr)
  );

  sg_walk_dp #(
    .PTR_W      (PTR_W),
    .MODE_W     (MODE_W),
    .LEN_SHIFT  (LEN_SHIFT),
    .ALIGN_LOG2 (ALIGN_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startPtr   (startPtr),
    .memRdData  (memRdData),
    .memRdAddr  (memRdAddr),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqOut     (reqOut),
    .reqOrdered (reqOrdered),
    .reqMode    (reqMode),
    .descLast   (descLast),
    .startBad   (startBad),
    .nextBad    (nextBad)
  );

  assign memRdEn = ctl.rdEn;

  // R5: request fields frozen while stalled.
  a_r5_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(reqAddr) && $stable(reqLen) &&
      $stable(reqOut) && $stable(reqOrdered) && $stable(reqMode)));

  // R1: nothing is emitted on the first cycle after reset.
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!reqValid && !chainDone && !chainErr));

endmodule

// File: tb/sg_chain_walker_test.sv
module sg_chain_walker_test;

  localparam int PTR_W = 32;
  localparam int LEN_W = PTR_W + 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic              startStrobe;
  logic [PTR_W-1:0]  startPtr;
  logic              memRdEn;
  logic [PTR_W-1:0]  memRdAddr;
  logic [31:0]       memRdData = '0;
  logic              reqValid;
  logic              reqReady;
  logic [PTR_W-1:0]  reqAddr;
  logic [LEN_W-1:0]  reqLen;
  logic              reqOut;
  logic              reqOrdered;
  logic [3:0]        reqMode;
  logic              chainDone;
  logic              chainErr;

  always #10 clk = ~clk;  // 50 MHz

  sg_chain_walker uut (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .startPtr(startPtr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqOut(reqOut), .reqOrdered(reqOrdered),
    .reqMode(reqMode), .chainDone(chainDone), .chainErr(chainErr)
  );

  // Descriptor memory, one-cycle read latency.
  logic [31:0] mem [0:255];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr[9:2]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference model.
  typedef struct {
    logic [31:0]      base;
    logic [31:0]      addr;
    logic [LEN_W-1:0] len;
    logic             outb;
    logic             ord;
    logic [3:0]       mode;
  } expReq_t;

  expReq_t     expQ[$];
  bit          modelBusy = 0;
  int          fetchEdge = -1;
  logic [31:0] curBase = '0;
  int          termEdge = -100;
  int          termKind = 0;   // 1 done, 2 error
  int          finalKind = 0;
  bit          prevStall = 0;
  logic [PTR_W-1:0] pAddr;
  logic [LEN_W-1:0] pLen;
  logic        pOut, pOrd;
  logic [3:0]  pMode;
  int          readyMode = 0;

  task automatic buildChain(input logic [31:0] ptr);
    logic [31:0] p;
    p = ptr;
    expQ.delete();
    for (int n = 0; n < 32; n++) begin
      expReq_t e;
      logic [31:0] w2, w3;
      e.base = p;
      e.addr = mem[p[9:2]];
      e.len  = {3'b000, mem[p[9:2] + 8'd1]} << 3;
      w2 = mem[p[9:2] + 8'd2];
      w3 = mem[p[9:2] + 8'd3];
      e.ord  = w2[4];
      e.outb = w2[5];
      e.mode = w2[11:8];
      expQ.push_back(e);
      if (w2[7]) begin finalKind = 1; break; end
      if (w3 == 0 || w3[2:0] != 0) begin finalKind = 2; break; end
      p = w3;
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int  k;
      bit  expRd, expVal;
      // Start strobe (R9, R10): decided on the pre-handshake state.
      if (startStrobe) begin
        if (!modelBusy) begin
          if (startPtr == 0 || startPtr[2:0] != 0) begin
            termEdge = cyc + 1; termKind = 2;
          end else begin
            buildChain(startPtr);
            modelBusy = 1; fetchEdge = cyc + 1; curBase = startPtr;
          end
        end
      end
      // Read schedule and request timing (R2, R6, R7, R10).
      k = cyc - fetchEdge;
      expRd  = modelBusy && fetchEdge >= 0 && k >= 0 && k < 4;
      expVal = modelBusy && fetchEdge >= 0 && k >= 5;
      check(memRdEn == expRd, "R2", "memRdEn", memRdEn, expRd);
      if (expRd && memRdEn)
        check(memRdAddr == curBase + 32'(4 * k), "R2", "memRdAddr",
              memRdAddr, curBase + 32'(4 * k));
      check(reqValid == expVal, "R6", "reqValid", reqValid, expVal);
      // Stall stability (R5).
      if (prevStall) begin
        check(reqValid == 1'b1, "R5", "valid held", reqValid, 1);
        check(reqAddr == pAddr && reqLen == pLen && reqOut == pOut &&
              reqOrdered == pOrd && reqMode == pMode, "R5", "fields held",
              reqAddr, pAddr);
      end
      // Handshake: compare fields (R3, R4).
      if (reqValid && reqReady && expQ.size() > 0) begin
        expReq_t e;
        e = expQ.pop_front();
        check(reqAddr == e.addr, "R3", "reqAddr", reqAddr, e.addr);
        check(reqLen == e.len, "R3", "reqLen", reqLen, e.len);
        check(reqOut == e.outb, "R4", "reqOut", reqOut, e.outb);
        check(reqOrdered == e.ord, "R4", "reqOrdered", reqOrdered, e.ord);
        check(reqMode == e.mode, "R4", "reqMode", reqMode, e.mode);
        if (expQ.size() == 0) begin
          modelBusy = 0; fetchEdge = -1;
          termEdge = cyc + 1; termKind = finalKind;
        end else begin
          fetchEdge = cyc + 1; curBase = expQ[0].base;
        end
      end
      // End pulses (R7, R8, R9).
      check(chainDone == (cyc == termEdge && termKind == 1), "R7",
            "chainDone", chainDone, (cyc == termEdge && termKind == 1));
      check(chainErr == (cyc == termEdge && termKind == 2), "R8",
            "chainErr", chainErr, (cyc == termEdge && termKind == 2));
      prevStall = reqValid && !reqReady;
      pAddr = reqAddr; pLen = reqLen; pOut = reqOut;
      pOrd = reqOrdered; pMode = reqMode;
    end
  end

  // Ready pattern driver.
  logic [15:0] lfsr = 16'hACE1;
  initial begin
    reqReady = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqReady = (readyMode == 0) ? 1'b1 : lfsr[0];
    end
  end

  task automatic putDesc(input logic [31:0] p, input logic [31:0] a,
                         input logic [31:0] u, input logic [31:0] f,
                         input logic [31:0] nxt);
    mem[p[9:2]]        = a;
    mem[p[9:2] + 8'd1] = u;
    mem[p[9:2] + 8'd2] = f;
    mem[p[9:2] + 8'd3] = nxt;
  endtask

  task automatic startPulse(input logic [31:0] p);
    @(posedge clk); #2;
    startStrobe = 1'b1; startPtr = p;
    @(posedge clk); #2;
    startStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    @(posedge clk);
    while (modelBusy || cyc <= termEdge + 1) @(posedge clk);
  endtask

  task automatic runTests();
    // R1: reset state.
    rstN = 1'b0; startStrobe = 1'b0; startPtr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!reqValid && !memRdEn && !chainDone && !chainErr, "R1",
          "outputs in reset", {reqValid, memRdEn, chainDone, chainErr}, 0);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    check(!reqValid && !memRdEn && !chainDone && !chainErr, "R1",
          "outputs after reset", {reqValid, memRdEn, chainDone, chainErr}, 0);

    // R3, R4, R7: single end descriptor, junk in undecoded bits, nonzero next.
    putDesc(32'h040, 32'h1234_5678, 32'h0000_0201, 32'hA5A5_F9BF, 32'h080);
    putDesc(32'h080, 32'hDEAD_0000, 32'h1, 32'h80, 32'h0);
    startPulse(32'h040); waitIdle();

    // R5, R6: three-descriptor chain with a stalling consumer.
    readyMode = 1;
    putDesc(32'h100, 32'h0001_0000, 32'h10, 32'h0000_0410, 32'h180);
    putDesc(32'h180, 32'h0002_0000, 32'hFFFF_FFFF, 32'hFFFF_024F, 32'h1C8);
    putDesc(32'h1C8, 32'h0003_0008, 32'h3, 32'h0000_0680, 32'h0);
    startPulse(32'h100); waitIdle();

    // R8: zero next pointer without end bit.
    readyMode = 0;
    putDesc(32'h200, 32'h0000_7000, 32'h8, 32'h0000_0130, 32'h0);
    startPulse(32'h200); waitIdle();

    // R8: misaligned next pointer after one good hop.
    putDesc(32'h240, 32'h0000_8000, 32'h2, 32'h0, 32'h260);
    putDesc(32'h260, 32'h0000_9000, 32'h4, 32'h20, 32'h26C);
    startPulse(32'h240); waitIdle();

    // R9: bad start pointers.
    startPulse(32'h0); waitIdle();
    startPulse(32'h104); waitIdle();

    // R10: strobes during a stalled walk are ignored.
    readyMode = 1;
    fork
      startPulse(32'h100);
      begin
        repeat (3) @(posedge clk);
        startPulse(32'h044);
        repeat (4) @(posedge clk);
        startPulse(32'h040);
      end
    join
    waitIdle();

    // R6, R7: back-to-back walks with an always-ready consumer.
    readyMode = 0;
    startPulse(32'h100); waitIdle();
    startPulse(32'h040); waitIdle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks, nFails);
    $finish;
  end

endmodule